// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight independent 32-bit down-counters behind a word-wide register port. Every counter has a current-count word, a reload word and two match words. A four-bit control nibble per counter sits in one shared control word. Software writes a reload value, which also loads the counter, and sets the counter's enable bit. From then on the counter steps down once per step until it reaches zero. On the next step it reloads and inverts its own interrupt line, which gives periodic operation. A consumer of the interrupt therefore reacts to either edge of the line.

Each counter steps on one of two sources, chosen by its control nibble. The first is every bus clock cycle. The second is a slow tick, supplied as a one-cycle enable strobe `tick_us` that is asserted once per microsecond. The whole block therefore stays in one clock domain. Reads are combinational from the address, and writes take effect at the clock edge on which `bus_we` is high.

Top module: `tmr_bank`

## Requirements
- R1: Only word-aligned offsets below 0x100 are decoded. Counters 0 to 2 have their windows at 0x00, 0x10 and 0x20. Counters 3 to 7 have theirs at 0x40 through 0x80. Inside each window, +0x0 is the count, +0x4 is the reload and +0x8/+0xC are the two match words. The control word is at 0x30 and the auxiliary control word is at 0x34. Every other offset, including 0x38, 0x3C, 0x90 and any misaligned offset, reads zero and ignores writes.
- R2: Counter i owns control bits [4i+3:4i]. Bit 0 is enable, bit 1 selects the slow tick, bit 2 is the overflow interrupt enable (stored and read back) and bit 3 is the pulse enable. The pulse bit is stored only for counters 4 to 7 and reads zero for counters 0 to 3.
- R3: The auxiliary control word at 0x34 stores and returns whatever is written to it and has no other effect.
- R4: A write to a reload word sets both the stored reload value and the current count.
- R5: A write to a count word is taken only while that counter is enabled; otherwise it is ignored.
- R6: Both match words always read zero. Non-zero writes to them are discarded, so every expiry qualifies for an interrupt.
- R7: An enabled counter with the slow-tick bit clear steps once per clock. With the bit set, it steps only on cycles where `tick_us` is high.
- R8: A step taken at count zero loads the reload value and inverts that counter's `irq` bit. A reload of zero therefore toggles `irq` on every step.
- R9: A control write that clears a counter's enable bit stops it and loads its count from reload. Setting the bit resumes counting from the current count, starting on the cycle after the write. A disabled counter holds its count.
- R10: After reset, all counts, reloads, both control words and all `irq` bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle slow tick strobe |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 8 | Per-counter interrupt level, toggles on expiry |

## Verification
Counting is first tried on the slow tick with the strobe held off, which shows that a slow-tick counter ignores the bus clock. Hand-delivered ticks then step a counter through zero, showing both the reload and the exact tick on which `irq` inverts. A reload of zero is stepped repeatedly to confirm a toggle on every tick. A free-running bus-clock counter is read after a known number of cycles and then stopped, which separates the two clock sources and exposes the stop-time reload. Count writes made while a counter is off and while it is on tell the enable gating apart from plain storage.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // positions inside one control nibble
  localparam int B_EN    = 0;
  localparam int B_SLOW  = 1;
  localparam int B_OVF   = 2;
  localparam int B_PULSE = 3;

  // word inside a counter's 16-byte window
  typedef enum logic [1:0] {
    W_CNT = 2'd0,
    W_RLD = 2'd1,
    W_MA  = 2'd2,
    W_MB  = 2'd3
  } tmr_word_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_TMR  = 8,
  parameter int IDX_W  = $clog2(N_TMR)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_ctrl2,
  output logic              hit_chan,
  output logic [IDX_W-1:0]  idx,
  output tmr_word_e         word
);
  localparam logic [3:0] CTRL_WIN = 4'd3;
  localparam logic [3:0] LAST_WIN = 4'(N_TMR);

  logic [3:0] win;
  logic [3:0] win_m1;
  logic       aligned;

  assign win     = addr[7:4];
  assign win_m1  = win - 4'd1;
  assign aligned = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:8] == '0);
  assign word    = tmr_word_e'(addr[3:2]);

  always_comb begin
    hit_ctrl  = 1'b0;
    hit_ctrl2 = 1'b0;
    hit_chan  = 1'b0;
    idx       = '0;
    if (aligned) begin
      if (win < CTRL_WIN) begin
        hit_chan = 1'b1;
        idx      = win[IDX_W-1:0];
      end else if (win == CTRL_WIN) begin
        hit_ctrl  = (addr[3:2] == 2'd0);
        hit_ctrl2 = (addr[3:2] == 2'd1);
      end else if (win <= LAST_WIN) begin
        hit_chan = 1'b1;
        idx      = win_m1[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             slow,
  input  logic             tick_us,
  input  logic             stop_ld,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             lvl_q, lvl_d;
  logic             step;
  logic             upd;

  assign step = en & (slow ? tick_us : 1'b1);
  assign upd  = stop_ld | wr_rld | (wr_cnt & en) | step;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    lvl_d = lvl_q;
    if (stop_ld) begin
      cnt_d = rld_q;
    end else if (wr_rld) begin
      rld_d = wdata;
      cnt_d = wdata;
    end else if (wr_cnt && en) begin
      cnt_d = wdata;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d = rld_q;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      lvl_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      lvl_q <= lvl_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = lvl_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int NIB_W       = 4,
  parameter int PULSE_FIRST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  irq
);
  localparam int IDX_W  = $clog2(N_TMR);
  localparam int CTRL_W = N_TMR * NIB_W;

  logic              hit_ctrl, hit_ctrl2, hit_chan;
  logic [IDX_W-1:0]  idx;
  tmr_word_e         word;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d, ctrl_mask;
  logic [DATA_W-1:0] ctrl2_q;
  logic              ctrl_we, ctrl2_we;
  logic [DATA_W-1:0] cnt_a [N_TMR];
  logic [DATA_W-1:0] rld_a [N_TMR];

  tmr_decode #(.ADDR_W(ADDR_W), .N_TMR(N_TMR), .IDX_W(IDX_W)) dec_i (
    .addr     (bus_addr),
    .hit_ctrl (hit_ctrl),
    .hit_ctrl2(hit_ctrl2),
    .hit_chan (hit_chan),
    .idx      (idx),
    .word     (word)
  );

  assign ctrl_we  = bus_we & hit_ctrl;
  assign ctrl2_we = bus_we & hit_ctrl2;
  assign ctrl_d   = bus_wdata[CTRL_W-1:0] & ctrl_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ctrl2_q <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_d;
      if (ctrl2_we) ctrl2_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_chan
    // pulse capability only from PULSE_FIRST upward
    if (g >= PULSE_FIRST) begin : g_pulse
      assign ctrl_mask[g*NIB_W +: NIB_W] = {NIB_W{1'b1}};
    end else begin : g_nopulse
      assign ctrl_mask[g*NIB_W +: NIB_W] = ~(NIB_W'(1) << B_PULSE);
    end

    logic en_bit, sel_me;
    assign en_bit = ctrl_q[g*NIB_W + B_EN];
    assign sel_me = bus_we & hit_chan & (idx == IDX_W'(g));

    tmr_chan #(.CNT_W(DATA_W)) chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_bit),
      .slow   (ctrl_q[g*NIB_W + B_SLOW]),
      .tick_us(tick_us),
      .stop_ld(ctrl_we & en_bit & ~bus_wdata[g*NIB_W + B_EN]),
      .wr_cnt (sel_me & (word == W_CNT)),
      .wr_rld (sel_me & (word == W_RLD)),
      .wdata  (bus_wdata),
      .cnt_o  (cnt_a[g]),
      .rld_o  (rld_a[g]),
      .irq_o  (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata = DATA_W'(ctrl_q);
    end else if (hit_ctrl2) begin
      bus_rdata = ctrl2_q;
    end else if (hit_chan) begin
      case (word)
        W_CNT:   bus_rdata = cnt_a[idx];
        W_RLD:   bus_rdata = rld_a[idx];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N_TMR  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_TMR*NIB_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnt_a [N_TMR],
  input logic [DATA_W-1:0] rld_a [N_TMR],
  input logic [N_TMR-1:0]  irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(48);

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(((i < 3) ? i : i + 1) * 16);
    localparam int ENB = i * NIB_W;

    AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == BASE + ADDR_W'(4)) |=>
        (rld_a[i] == $past(bus_wdata) && cnt_a[i] == $past(bus_wdata))); // R4

    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == BASE && ctrl_q[ENB]) |=>
        (cnt_a[i] == $past(bus_wdata))); // R5

    AST_STOP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CTRL_ADDR && ctrl_q[ENB] && !bus_wdata[ENB]) |=>
        (cnt_a[i] == $past(rld_a[i]))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[ENB] && !bus_we) |=> (cnt_a[i] == $past(cnt_a[i]))); // R9

    AST_TOGGLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] != $past(irq[i])) |->
        ($past(cnt_a[i]) == '0 && $past(ctrl_q[ENB]))); // R8
  end
endmodule

bind tmr_bank tmr_bank_chk #(
  .N_TMR (N_TMR),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .NIB_W (NIB_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .ctrl_q   (ctrl_q),
  .cnt_a    (cnt_a),
  .rld_a    (rld_a),
  .irq      (irq)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic        tick_us;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  irq;

  int n_chk;
  int n_bad;
  bit done;

  tmr_bank dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_us  (tick_us),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [31:0] val;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h030, 32'h8888_CCCC, 8'd2},  // R2 write all pulse/ovf bits
    '{1'b1, 12'h030, 32'h8888_4444, 8'd2},  // R2 pulse kept only on 4..7
    '{1'b0, 12'h030, 32'h0000_0000, 8'd2},
    '{1'b0, 12'h034, 32'hA5A5_0001, 8'd3},  // R3
    '{1'b1, 12'h034, 32'hA5A5_0001, 8'd3},
    '{1'b1, 12'h030, 32'h0000_0000, 8'd3},  // R3 no side effect
    '{1'b0, 12'h014, 32'h0000_1234, 8'd4},  // R4
    '{1'b1, 12'h014, 32'h0000_1234, 8'd4},
    '{1'b1, 12'h010, 32'h0000_1234, 8'd4},
    '{1'b0, 12'h010, 32'h0000_0055, 8'd5},  // R5 disabled count write
    '{1'b1, 12'h010, 32'h0000_1234, 8'd5},
    '{1'b0, 12'h048, 32'h0000_0007, 8'd6},  // R6
    '{1'b1, 12'h048, 32'h0000_0000, 8'd6},
    '{1'b0, 12'h04C, 32'h0000_0000, 8'd6},
    '{1'b1, 12'h04C, 32'h0000_0000, 8'd6},
    '{1'b0, 12'h038, 32'h0000_FFFF, 8'd1},  // R1 unmapped
    '{1'b1, 12'h038, 32'h0000_0000, 8'd1},
    '{1'b1, 12'h03C, 32'h0000_0000, 8'd1},
    '{1'b1, 12'h090, 32'h0000_0000, 8'd1},
    '{1'b0, 12'h013, 32'h0000_0077, 8'd1},  // R1 misaligned write
    '{1'b1, 12'h014, 32'h0000_1234, 8'd1},
    '{1'b0, 12'h084, 32'h0000_BEEF, 8'd1},  // R1 last window
    '{1'b1, 12'h080, 32'h0000_BEEF, 8'd1}
  };

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic [7:0] exp, input string req);
    #1;
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    tick_us = 1'b0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_chk(12'h030, 32'h0, "R10");
    rd_chk(12'h034, 32'h0, "R10");
    rd_chk(12'h000, 32'h0, "R10");
    rd_chk(12'h084, 32'h0, "R10");
    irq_chk(8'h00, "R10");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].rd) rd_chk(VEC[k].addr, VEC[k].val, $sformatf("R%0d", VEC[k].req));
      else wr(VEC[k].addr, VEC[k].val);
    end

    // R7/R8: counter 4 on slow tick, reload 2
    wr(12'h054, 32'd2);
    wr(12'h030, 32'h0003_0000);
    repeat (3) @(negedge clk);
    rd_chk(12'h050, 32'd2, "R7");
    tick(1); rd_chk(12'h050, 32'd1, "R7");
    tick(1); rd_chk(12'h050, 32'd0, "R7"); irq_chk(8'h00, "R8");
    tick(1); rd_chk(12'h050, 32'd2, "R8"); irq_chk(8'h10, "R8");
    tick(3); rd_chk(12'h050, 32'd2, "R8"); irq_chk(8'h00, "R8");

    // R9 stop reloads
    tick(1); rd_chk(12'h050, 32'd1, "R9");
    wr(12'h030, 32'h0);
    rd_chk(12'h050, 32'd2, "R9");
    tick(2); rd_chk(12'h050, 32'd2, "R9");

    // R5 gated count write, R9 resume from current count
    wr(12'h050, 32'd77); rd_chk(12'h050, 32'd2, "R5");
    wr(12'h030, 32'h0003_0000);
    wr(12'h050, 32'd77); rd_chk(12'h050, 32'd77, "R5");
    tick(1); rd_chk(12'h050, 32'd76, "R9");
    wr(12'h030, 32'h0);

    // R8 reload zero toggles each step (counter 1)
    wr(12'h014, 32'd0);
    wr(12'h030, 32'h0000_0030);
    tick(1); irq_chk(8'h02, "R8");
    tick(1); irq_chk(8'h00, "R8");
    tick(1); irq_chk(8'h02, "R8");
    rd_chk(12'h010, 32'd0, "R8");
    wr(12'h030, 32'h0);

    // R7 bus-clock stepping on counter 0
    wr(12'h004, 32'd100);
    wr(12'h030, 32'h0000_0001);
    repeat (5) @(negedge clk);
    rd_chk(12'h000, 32'd95, "R7");
    wr(12'h030, 32'h0);
    rd_chk(12'h000, 32'd100, "R9");
    irq_chk(8'h02, "R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule